// File: doc/BRIEF.md
# Pipeline Status Pulse Decoder

This block watches two active-low lines coming out of a processor: a pipeline-status line and an instruction-fetch line. It turns the status line into discrete events. The length of each low pulse on that line says what the core did. A single low cycle means an extension word was taken from the second queue stage. Two low cycles mean a new instruction has started. A merged run of three low cycles carries both events: a start followed by an extension-word use. The fetch line is simply counted.

Both lines are captured on the falling clock edge. Every decision is made by a run-length state machine that moves on the rising edge. The results appear as single-cycle strobes. A run that is longer than any legal pulse is reported as a protocol error. After such an error the decoder ignores the line until it has seen a fixed number of idle cycles, and only then accepts new pulses. The block runs the same way whether or not the core is recirculating a loop internally. During loop mode the status line keeps reporting and the fetch line simply falls silent.

Top module: `psd_pipe_decoder`

## Requirements
- R1: Both input lines are sampled only on the falling clock edge. A low level present around the falling edge and gone by the rising edge counts as one asserted sample. A low level that touches only a rising edge is never seen.
- R2: A run of exactly one asserted (low) status sample followed by a negated sample gives one `ext_used` pulse. The pulse is high during the clock cycle that begins at the first rising edge after the negated sample is captured.
- R3: A run of exactly two asserted samples gives one `insn_start` pulse. The pulse is high in the cycle that begins at the first rising edge after the second asserted sample, and no extension strobe follows.
- R4: A run of exactly three asserted samples gives `insn_start` after the second sample. After the negated sample that ends the run, it gives `ext_used` one time.
- R5: A run of four or more asserted samples gives `insn_start` after the second sample. It gives `proto_err` after the fourth sample, and the third sample gives no `ext_used`.
- R6: After `proto_err`, all status activity is ignored until RESYNC_LEN consecutive negated samples have been captured. Pulses that start before then produce no strobe, and the first pulse after them is decoded normally.
- R7: Runs separated by a single negated sample are decoded independently. The counts of strobes over any pattern follow R2 to R6 applied run by run.
- R8: `fetch_cnt` increases by one for each asserted fetch sample, wraps modulo 2^FETCH_W and holds otherwise. It is not affected by the status line.
- R9: While `rst_n` is low, all strobes are low and `fetch_cnt` is zero, whatever the input lines do.
- R10: At most one of `ext_used`, `insn_start` and `proto_err` is high in any cycle. None of them stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_stat_n | input | 1 | Active-low pipeline status line, sampled on the falling edge |
| fetch_n | input | 1 | Active-low instruction-fetch line, sampled on the falling edge |
| ext_used | output | 1 | One-cycle strobe: an extension word was consumed |
| insn_start | output | 1 | One-cycle strobe: a new instruction began |
| proto_err | output | 1 | One-cycle strobe: an asserted run longer than three samples |
| fetch_cnt | output | FETCH_W | Wrapping count of asserted fetch samples |

## Verification
The bench sweeps every 10-cycle status pattern. This covers every arrangement of back-to-back and merged runs. A decoder that confirmed extension use too early would split a two-cycle start into an extension plus something else. A decoder that reset its run count on the third cycle would miss the merged start-plus-extension, or would fail to flag an overlong run. Directed cases target the resync window one cycle short and one cycle long. A decoder that left resync on the first idle cycle would decode a pulse that must be ignored. Narrow pulses placed around each clock edge show that only the falling edge samples. A fetch run longer than the counter range shows that the counter wraps and is not affected by status traffic.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Position inside a run of asserted status samples
  typedef enum logic [2:0] {
    RUN_IDLE   = 3'd0,
    RUN_ONE    = 3'd1,
    RUN_TWO    = 3'd2,
    RUN_THREE  = 3'd3,
    RUN_RESYNC = 3'd4
  } run_state_e;

  // Decoded events, registered together
  typedef struct packed {
    logic ext;
    logic start;
    logic err;
  } evt_t;

  localparam int unsigned LINE_STAT  = 0;
  localparam int unsigned LINE_FETCH = 1;
  localparam int unsigned NUM_LINES  = 2;

endpackage

// File: rtl/psd_edge_sampler.sv
module psd_edge_sampler #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_n,
  output logic [LINES-1:0] active
);

  // One falling-edge capture flop per line; stored active-high
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic cap_q;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q <= 1'b0;
      end else begin
        cap_q <= ~lines_n[g];
      end
    end
    assign active[g] = cap_q;
  end

endmodule

// File: rtl/psd_run_classifier.sv
module psd_run_classifier
  import psd_pkg::*;
#(
  parameter int unsigned RESYNC_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output evt_t evt
);

  localparam int unsigned CW       = (RESYNC_LEN < 2) ? 1 : $clog2(RESYNC_LEN);
  localparam logic [CW-1:0] IDLE_LAST = CW'(RESYNC_LEN - 1);

  run_state_e       state_q, state_d;
  logic [CW-1:0]    idle_q, idle_d;
  evt_t             evt_q, evt_d;

  always_comb begin
    state_d = state_q;
    idle_d  = idle_q;
    evt_d   = '0;
    unique case (state_q)
      RUN_IDLE: begin
        if (act) state_d = RUN_ONE;
      end
      RUN_ONE: begin
        if (act) begin
          state_d     = RUN_TWO;
          evt_d.start = 1'b1;
        end else begin
          state_d   = RUN_IDLE;
          evt_d.ext = 1'b1;
        end
      end
      RUN_TWO: begin
        state_d = act ? RUN_THREE : RUN_IDLE;
      end
      RUN_THREE: begin
        if (act) begin
          state_d   = RUN_RESYNC;
          idle_d    = '0;
          evt_d.err = 1'b1;
        end else begin
          state_d   = RUN_IDLE;
          evt_d.ext = 1'b1;
        end
      end
      RUN_RESYNC: begin
        if (act) begin
          idle_d = '0;
        end else if (idle_q == IDLE_LAST) begin
          idle_d  = '0;
          state_d = RUN_IDLE;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
      default: begin
        state_d = RUN_IDLE;
        idle_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      idle_q  <= '0;
      evt_q   <= '0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      evt_q   <= evt_d;
    end
  end

  assign evt = evt_q;

endmodule

// File: rtl/psd_fetch_counter.sv
module psd_fetch_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/psd_pipe_decoder.sv
module psd_pipe_decoder
  import psd_pkg::*;
#(
  parameter int unsigned RESYNC_LEN = 4,
  parameter int unsigned FETCH_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pipe_stat_n,
  input  logic               fetch_n,
  output logic               ext_used,
  output logic               insn_start,
  output logic               proto_err,
  output logic [FETCH_W-1:0] fetch_cnt
);

  logic [NUM_LINES-1:0] lines_n;
  logic [NUM_LINES-1:0] lines_act;
  logic                 stat_act;
  logic                 fetch_act;
  evt_t                 evt;

  assign lines_n[LINE_STAT]  = pipe_stat_n;
  assign lines_n[LINE_FETCH] = fetch_n;

  psd_edge_sampler #(.LINES(NUM_LINES)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_n (lines_n),
    .active  (lines_act)
  );

  assign stat_act  = lines_act[LINE_STAT];
  assign fetch_act = lines_act[LINE_FETCH];

  psd_run_classifier #(.RESYNC_LEN(RESYNC_LEN)) u_classifier (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (stat_act),
    .evt   (evt)
  );

  psd_fetch_counter #(.WIDTH(FETCH_W)) u_fetch (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fetch_act),
    .count (fetch_cnt)
  );

  assign ext_used   = evt.ext;
  assign insn_start = evt.start;
  assign proto_err  = evt.err;

endmodule

// File: rtl/psd_pipe_decoder_chk.sv
module psd_pipe_decoder_chk #(
  parameter int unsigned FETCH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stat_smp,
  input logic               fetch_smp,
  input logic               ext_used,
  input logic               insn_start,
  input logic               proto_err,
  input logic [FETCH_W-1:0] fetch_cnt
);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_used, insn_start, proto_err}));

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start |=> !insn_start);

  // R10
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_used |=> !ext_used);

  // R3
  start_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start |-> ($past(stat_smp) && $past(stat_smp, 2)));

  // R2
  ext_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_used |-> (!$past(stat_smp) && $past(stat_smp, 2)));

  // R5
  err_after_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(stat_smp) && $past(stat_smp, 2) &&
                   $past(stat_smp, 3) && $past(stat_smp, 4)));

  // R8
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_smp |=> (fetch_cnt == $past(fetch_cnt) + 1'b1));

  // R8
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_smp |=> $stable(fetch_cnt));

endmodule

bind psd_pipe_decoder psd_pipe_decoder_chk #(.FETCH_W(FETCH_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .stat_smp   (stat_act),
  .fetch_smp  (fetch_act),
  .ext_used   (ext_used),
  .insn_start (insn_start),
  .proto_err  (proto_err),
  .fetch_cnt  (fetch_cnt)
);

// File: tb/psd_pipe_decoder_tb_top.sv
`timescale 1ns/100ps
module psd_pipe_decoder_tb_top;

  localparam int unsigned RESYNC_LEN = 4;
  localparam int unsigned FETCH_W    = 8;
  localparam int          SWEEP_N    = 10;
  localparam int          TAIL       = RESYNC_LEN + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_stat_n = 1'b1;
  logic fetch_n = 1'b1;
  logic ext_used, insn_start, proto_err;
  logic [FETCH_W-1:0] fetch_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int rec_ext [64];
  int rec_start [64];
  int rec_err [64];
  int tot_ext, tot_start, tot_err;
  int n_overlap, n_wide;

  always #2 clk = ~clk;

  psd_pipe_decoder #(.RESYNC_LEN(RESYNC_LEN), .FETCH_W(FETCH_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_stat_n(pipe_stat_n),
    .fetch_n    (fetch_n),
    .ext_used   (ext_used),
    .insn_start (insn_start),
    .proto_err  (proto_err),
    .fetch_cnt  (fetch_cnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bit c = 1 drives the status line low during cycle c; rec[c] holds
  // the outputs seen in the cycle after sample c-1 was captured.
  task automatic drive_seq(input logic [63:0] bits, input int n);
    int p_start, p_ext;
    tot_ext = 0; tot_start = 0; tot_err = 0;
    p_start = 0; p_ext = 0;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      pipe_stat_n = ~bits[c];
      @(negedge clk); #0.5;
      rec_ext[c]   = int'(ext_used);
      rec_start[c] = int'(insn_start);
      rec_err[c]   = int'(proto_err);
      tot_ext   += rec_ext[c];
      tot_start += rec_start[c];
      tot_err   += rec_err[c];
      if (rec_ext[c] + rec_start[c] + rec_err[c] > 1) n_overlap++;
      if ((p_start == 1 && rec_start[c] == 1) || (p_ext == 1 && rec_ext[c] == 1)) n_wide++;
      p_start = rec_start[c];
      p_ext   = rec_ext[c];
    end
  endtask

  // Expected strobe counts from the run-length rules
  task automatic model(input logic [63:0] bits, input int n,
                       output int e, output int s, output int r);
    int i, zc, run;
    bit blocked;
    e = 0; s = 0; r = 0; i = 0; zc = 0; blocked = 1'b0;
    while (i < n) begin
      if (blocked) begin
        if (bits[i]) zc = 0;
        else begin
          zc++;
          if (zc == RESYNC_LEN) blocked = 1'b0;
        end
        i++;
      end else if (!bits[i]) begin
        i++;
      end else begin
        run = 0;
        while (i + run < n && bits[i + run]) run++;
        if (run == 1) e++;
        else if (run == 2) s++;
        else if (run == 3) begin s++; e++; end
        else begin s++; r++; blocked = 1'b1; zc = 0; run = 4; end
        i += run;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      pipe_stat_n = 1'b1;
    end
  endtask

  initial begin
    int e, s, r, hits;
    logic [63:0] b;
    n_overlap = 0; n_wide = 0;

    // R9: reset holds outputs at zero regardless of line activity
    pipe_stat_n = 1'b0; fetch_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); #0.5;
    check("R9", "strobes in reset", int'(ext_used | insn_start | proto_err), 0);
    check("R9", "fetch_cnt in reset", int'(fetch_cnt), 0);
    pipe_stat_n = 1'b1; fetch_n = 1'b1;
    @(posedge clk); #1; rst_n = 1'b1;
    idle(3);
    @(negedge clk); #0.5;
    check("R9", "fetch_cnt after reset", int'(fetch_cnt), 0);

    // R2: single pulse, extension strobe timing
    drive_seq(64'b1, 6);
    check("R2", "ext cycle", rec_ext[2], 1);
    check("R2", "ext total", tot_ext, 1);
    check("R2", "start total", tot_start, 0);

    // R3: two-cycle pulse, start timing
    drive_seq(64'b11, 6);
    check("R3", "start cycle", rec_start[2], 1);
    check("R3", "start total", tot_start, 1);
    check("R3", "ext total", tot_ext, 0);

    // R4: merged start plus extension
    drive_seq(64'b111, 8);
    check("R4", "start cycle", rec_start[2], 1);
    check("R4", "ext cycle", rec_ext[4], 1);
    check("R4", "ext total", tot_ext, 1);

    // R5: overlong run
    drive_seq(64'b1111, 12);
    check("R5", "start cycle", rec_start[2], 1);
    check("R5", "err cycle", rec_err[4], 1);
    check("R5", "ext total", tot_ext, 0);
    check("R5", "err total", tot_err, 1);

    // R6: pulse one idle cycle too early is ignored
    b = 64'b0; b[3:0] = 4'hF; b[RESYNC_LEN + 3] = 1'b1;
    drive_seq(b, 16);
    check("R6", "early pulse ignored (ext)", tot_ext, 0);
    check("R6", "err total", tot_err, 1);
    // R6: pulse after a full idle window is decoded
    b = 64'b0; b[3:0] = 4'hF; b[RESYNC_LEN + 4] = 1'b1;
    drive_seq(b, 16);
    check("R6", "pulse after window", tot_ext, 1);
    check("R6", "ext cycle", rec_ext[RESYNC_LEN + 6], 1);

    // R7: back-to-back runs
    drive_seq(64'b0101, 8);
    check("R7", "ext first", rec_ext[2], 1);
    check("R7", "ext second", rec_ext[4], 1);
    drive_seq(64'b11011, 9);
    check("R7", "two starts", tot_start, 2);
    check("R7", "no ext", tot_ext, 0);

    // R1: narrow pulse around the falling edge is seen
    hits = 0;
    @(posedge clk); #1.5; pipe_stat_n = 1'b0; #1; pipe_stat_n = 1'b1;
    for (int c = 0; c < 4; c++) begin @(negedge clk); #0.5; hits += int'(ext_used); end
    check("R1", "falling-edge pulse ext", hits, 1);
    // R1: narrow pulse around the rising edge is not seen
    hits = 0;
    @(negedge clk); #1.5; pipe_stat_n = 1'b0; #1; pipe_stat_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #0.5; hits += int'(ext_used | insn_start | proto_err);
    end
    check("R1", "rising-edge pulse ignored", hits, 0);
    idle(2);

    // R7 sweep of every 10-cycle status pattern (R2..R6 per run)
    for (int p = 0; p < (1 << SWEEP_N); p++) begin
      b = 64'(p);
      model(b, SWEEP_N + TAIL, e, s, r);
      drive_seq(b, SWEEP_N + TAIL);
      check("R7", $sformatf("sweep %0h ext", p), tot_ext, e);
      check("R7", $sformatf("sweep %0h start", p), tot_start, s);
      check("R7", $sformatf("sweep %0h err", p), tot_err, r);
    end
    check("R10", "overlapping strobes", n_overlap, 0);
    check("R10", "two-cycle strobes", n_wide, 0);

    // R8: fetch counting wraps and ignores status line
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1;
      fetch_n = 1'b0;
      pipe_stat_n = c[1];
    end
    @(posedge clk); #1; fetch_n = 1'b1; pipe_stat_n = 1'b1;
    idle(RESYNC_LEN + 3);
    @(negedge clk); #0.5;
    check("R8", "fetch wrap count", int'(fetch_cnt), 300 % (1 << FETCH_W));
    drive_seq(64'h0F0F_3355, 40);
    @(negedge clk); #0.5;
    check("R8", "fetch hold under status", int'(fetch_cnt), 300 % (1 << FETCH_W));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule